// File: doc/BRIEF.md
# Wide Row Shuffle Stage

This stage reshapes one wide byte row per accepted command before the row is handed to a SIMD compute array. A command picks one or two operand rows from eight sources: the incoming memory row, four internal row registers, a constant zero row, a constant all-ones row, and the stage's own last result. It then applies one of five operations in a single clock. The operations are pass, rotate, per-slice broadcast, masked two-input merge, and pairwise-max compress.

The result goes into the row register named by the command. It also appears on the output stream together with that register number. Because the result is registered, it can be used as an operand by the very next command.

Both edges of the block are valid/ready streams. A command is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output holds no result, or when the held result is taken in the same cycle. While `out_valid` is high and `out_ready` is low, the output row and register number stay frozen. During that time no command is accepted and no register changes.

Top module: `rsu_row_shuffle`

## Requirements
- R1: After reset, `out_valid` is 0 and all four row registers and the last-result row read as all-zero bytes.
- R2: `in_ready` is 1 exactly when `out_valid` is 0 or `out_ready` is 1. While `out_valid` is 1 and `out_ready` is 0, `out_row`, `out_dst` and `out_valid` hold their values.
- R3: An accepted command drives its result on `out_row`, with `out_valid` = 1 and `out_dst` = `in_dst`, on the next cycle. It also writes the result into row register `in_dst`, which a following command can read.
- R4: The source codes on `in_src_a`/`in_src_b` are: 0 = `in_row`, 1..4 = row registers 0..3, 5 = all-zero row, 6 = all-ones row (every byte 0xFF), 7 = last result.
- R5: Rotate (op 1) with `in_amt` = k in 0..6 gives result byte i = A byte ((i + 2^k) mod ROW_BYTES). Bytes move toward lower indices and wrap around the whole row.
- R6: Rotate with `in_amt` = 7 shifts by minus one: result byte i = A byte ((i - 1) mod ROW_BYTES).
- R7: Broadcast (op 2) copies A byte (s*SLICE_BYTES + `in_bidx`) to every byte of slice s, for each slice s.
- R8: Merge (op 3) gives result byte i = B byte i when bit 0 of byte i of row register `in_mask_sel` is 1, and A byte i otherwise.
- R9: Compress (op 4) gives result byte i = the unsigned maximum of A bytes 2i and 2i+1 for i below ROW_BYTES/2. The upper half of the result is zero.
- R10: Op 0 and the unused codes 5..7 pass A through unchanged.
- R11: A command that is presented while `in_ready` is 0 changes no row register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Command and row present |
| in_ready | output | 1 | Stage can accept a command |
| in_row | input | ROW_BYTES*8 | Row from the memory read port |
| in_op | input | 3 | Operation code |
| in_src_a | input | 3 | First operand source |
| in_src_b | input | 3 | Second operand source (merge) |
| in_mask_sel | input | 2 | Register holding the merge mask |
| in_amt | input | 3 | Rotate amount code |
| in_bidx | input | log2(SLICE_BYTES) | Broadcast byte index within a slice |
| in_dst | input | 2 | Destination row register |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_row | output | ROW_BYTES*8 | Result row |
| out_dst | output | 2 | Register the result was written to |

## Verification
The hardest case to reach is a command that arrives while a result is stalled on the output. That command must leave every register untouched. The proof of this only shows up later, through an ordinary read. The stimulus reaches this case in three steps. First it drops `out_ready` after an accepted command. Next it holds a pending write of all-ones into register 0 for several cycles, checking that `in_ready` stays low and the output is frozen. Finally it releases the stall with `in_valid` low and passes register 0 to the output to show it is still zero. A counting byte pattern on `in_row`, where byte i holds i, makes every rotate, broadcast and compress result predictable from a single probed byte.

// File: rtl/rsu_pkg.sv
`timescale 1ns/1ps
package rsu_pkg;
  typedef enum logic [2:0] {
    OP_PASS  = 3'd0,
    OP_ROT   = 3'd1,
    OP_BCAST = 3'd2,
    OP_MERGE = 3'd3,
    OP_CMPR  = 3'd4
  } rsu_op_e;

  localparam logic [2:0] SRC_RAM  = 3'd0;
  localparam logic [2:0] SRC_ZERO = 3'd5;
  localparam logic [2:0] SRC_ONES = 3'd6;
  localparam logic [2:0] SRC_LAST = 3'd7;
  localparam logic [2:0] AMT_NEG1 = 3'd7;
  localparam int         NUM_REGS = 4;
endpackage

// File: rtl/rsu_src_mux.sv
`timescale 1ns/1ps
module rsu_src_mux #(
  parameter int ROW_BYTES = 256,
  localparam int W = ROW_BYTES * 8
) (
  input  logic [2:0]                         sel,
  input  logic [W-1:0]                       ram_row,
  input  logic [rsu_pkg::NUM_REGS-1:0][W-1:0] regs,
  input  logic [W-1:0]                       last_row,
  output logic [W-1:0]                       row
);
  always_comb begin
    unique case (sel)
      rsu_pkg::SRC_RAM:  row = ram_row;
      3'd1:              row = regs[0];
      3'd2:              row = regs[1];
      3'd3:              row = regs[2];
      3'd4:              row = regs[3];
      rsu_pkg::SRC_ZERO: row = '0;
      rsu_pkg::SRC_ONES: row = '1;
      default:           row = last_row;
    endcase
  end
endmodule

// File: rtl/rsu_shuffle.sv
`timescale 1ns/1ps
module rsu_shuffle #(
  parameter int ROW_BYTES   = 256,
  parameter int SLICE_BYTES = 64,
  localparam int W      = ROW_BYTES * 8,
  localparam int IW     = $clog2(ROW_BYTES),
  localparam int SW     = $clog2(SLICE_BYTES),
  localparam int SLICES = ROW_BYTES / SLICE_BYTES,
  localparam int HALF   = ROW_BYTES / 2
) (
  input  rsu_pkg::rsu_op_e op,
  input  logic [2:0]       amt,
  input  logic [SW-1:0]    bidx,
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  input  logic [W-1:0]     mask,
  output logic [W-1:0]     res
);
  logic [W-1:0]  rot_r, bc_r, mg_r, cp_r;
  logic [IW-1:0] shift;

  always_comb begin
    if (amt == rsu_pkg::AMT_NEG1) shift = IW'(ROW_BYTES - 1);
    else                          shift = IW'(1) << amt;
  end

  genvar gi, gs;
  generate
    for (gi = 0; gi < ROW_BYTES; gi++) begin : g_byte
      logic [IW-1:0] src_idx;
      assign src_idx = IW'(gi) + shift;
      assign rot_r[gi*8 +: 8] = a[src_idx*8 +: 8];
      assign mg_r[gi*8 +: 8]  = mask[gi*8] ? b[gi*8 +: 8] : a[gi*8 +: 8];
      if (gi < HALF) begin : g_lo
        logic [7:0] ev, od;
        assign ev = a[(2*gi)*8 +: 8];
        assign od = a[(2*gi+1)*8 +: 8];
        assign cp_r[gi*8 +: 8] = (ev > od) ? ev : od;
      end else begin : g_hi
        assign cp_r[gi*8 +: 8] = 8'h00;
      end
    end
    for (gs = 0; gs < SLICES; gs++) begin : g_slice
      logic [SLICE_BYTES*8-1:0] sl;
      logic [7:0]               pick;
      assign sl   = a[gs*SLICE_BYTES*8 +: SLICE_BYTES*8];
      assign pick = sl[bidx*8 +: 8];
      assign bc_r[gs*SLICE_BYTES*8 +: SLICE_BYTES*8] = {SLICE_BYTES{pick}};
    end
  endgenerate

  always_comb begin
    case (op)
      rsu_pkg::OP_ROT:   res = rot_r;
      rsu_pkg::OP_BCAST: res = bc_r;
      rsu_pkg::OP_MERGE: res = mg_r;
      rsu_pkg::OP_CMPR:  res = cp_r;
      default:           res = a;
    endcase
  end
endmodule

// File: rtl/rsu_regfile.sv
`timescale 1ns/1ps
module rsu_regfile #(
  parameter int ROW_BYTES = 256,
  localparam int W = ROW_BYTES * 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                we,
  input  logic [1:0]                          waddr,
  input  logic [W-1:0]                        wdata,
  input  logic [1:0]                          mask_sel,
  output logic [rsu_pkg::NUM_REGS-1:0][W-1:0] regs,
  output logic [W-1:0]                        mask_row
);
  genvar gr;
  generate
    for (gr = 0; gr < rsu_pkg::NUM_REGS; gr++) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n)                        regs[gr] <= '0;
        else if (we && waddr == 2'(gr))    regs[gr] <= wdata;
      end
    end
  endgenerate

  assign mask_row = regs[mask_sel];
endmodule

// File: rtl/rsu_row_shuffle.sv
`timescale 1ns/1ps
module rsu_row_shuffle #(
  parameter int ROW_BYTES   = 256,
  parameter int SLICE_BYTES = 64,
  localparam int W  = ROW_BYTES * 8,
  localparam int SW = $clog2(SLICE_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_row,
  input  logic [2:0]    in_op,
  input  logic [2:0]    in_src_a,
  input  logic [2:0]    in_src_b,
  input  logic [1:0]    in_mask_sel,
  input  logic [2:0]    in_amt,
  input  logic [SW-1:0] in_bidx,
  input  logic [1:0]    in_dst,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  out_row,
  output logic [1:0]    out_dst
);
  logic [rsu_pkg::NUM_REGS-1:0][W-1:0] regs;
  logic [W-1:0] opa, opb, mask_row, result;
  logic         accept;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  rsu_src_mux #(.ROW_BYTES(ROW_BYTES)) u_mux_a (
    .sel(in_src_a), .ram_row(in_row), .regs(regs), .last_row(out_row), .row(opa));

  rsu_src_mux #(.ROW_BYTES(ROW_BYTES)) u_mux_b (
    .sel(in_src_b), .ram_row(in_row), .regs(regs), .last_row(out_row), .row(opb));

  rsu_regfile #(.ROW_BYTES(ROW_BYTES)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(accept), .waddr(in_dst), .wdata(result),
    .mask_sel(in_mask_sel), .regs(regs), .mask_row(mask_row));

  rsu_shuffle #(.ROW_BYTES(ROW_BYTES), .SLICE_BYTES(SLICE_BYTES)) u_shuf (
    .op(rsu_pkg::rsu_op_e'(in_op)), .amt(in_amt), .bidx(in_bidx),
    .a(opa), .b(opb), .mask(mask_row), .res(result));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_row   <= '0;
      out_dst   <= 2'd0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_row   <= result;
      out_dst   <= in_dst;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/rsu_checker.sv
`timescale 1ns/1ps
module rsu_checker #(
  parameter int ROW_BYTES   = 256,
  parameter int SLICE_BYTES = 64,
  localparam int W  = ROW_BYTES * 8,
  localparam int SW = $clog2(SLICE_BYTES)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [2:0]    in_op,
  input logic [1:0]    in_dst,
  input logic          out_valid,
  input logic          out_ready,
  input logic [W-1:0]  out_row,
  input logic [1:0]    out_dst
);
  p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> !out_valid);

  p_hold_row_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> ($stable(out_row) && $stable(out_dst) && out_valid));

  p_accept_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && out_dst == $past(in_dst)));

  p_bcast_uniform_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_op == 3'd2) |=>
      (out_row[7:0] == out_row[SLICE_BYTES*8-1 -: 8]));

  p_cmpr_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_op == 3'd4) |=> (out_row[W-1:W/2] == '0));
endmodule

bind rsu_row_shuffle rsu_checker #(.ROW_BYTES(ROW_BYTES), .SLICE_BYTES(SLICE_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
  .in_dst(in_dst), .out_valid(out_valid), .out_ready(out_ready), .out_row(out_row),
  .out_dst(out_dst));

// File: tb/tb_rsu_row_shuffle.sv
`timescale 1ns/1ps
module tb_rsu_row_shuffle;
  localparam int RB = 256;
  localparam int W  = RB * 8;
  // fields: op3 srcA3 srcB3 mask2 amt3 bidx6 dst2 probe8 expected8
  localparam int NV = 17;
  localparam logic [37:0] VEC [NV] = '{
    {3'd1,3'd0,3'd0,2'd0,3'd0,6'd0, 2'd0,8'd255,8'd0},   // R5 +1 wrap
    {3'd1,3'd0,3'd0,2'd0,3'd0,6'd0, 2'd0,8'd0,  8'd1},   // R5 +1
    {3'd1,3'd0,3'd0,2'd0,3'd1,6'd0, 2'd0,8'd254,8'd0},   // R5 +2
    {3'd1,3'd0,3'd0,2'd0,3'd2,6'd0, 2'd0,8'd10, 8'd14},  // R5 +4
    {3'd1,3'd0,3'd0,2'd0,3'd3,6'd0, 2'd0,8'd250,8'd2},   // R5 +8
    {3'd1,3'd0,3'd0,2'd0,3'd4,6'd0, 2'd0,8'd0,  8'd16},  // R5 +16
    {3'd1,3'd0,3'd0,2'd0,3'd5,6'd0, 2'd0,8'd230,8'd6},   // R5 +32
    {3'd1,3'd0,3'd0,2'd0,3'd6,6'd0, 2'd0,8'd200,8'd8},   // R5 +64
    {3'd1,3'd0,3'd0,2'd0,3'd7,6'd0, 2'd0,8'd0,  8'd255}, // R6 -1 wrap
    {3'd1,3'd0,3'd0,2'd0,3'd7,6'd0, 2'd0,8'd5,  8'd4},   // R6 -1
    {3'd2,3'd0,3'd0,2'd0,3'd0,6'd5, 2'd0,8'd70, 8'd69},  // R7
    {3'd2,3'd0,3'd0,2'd0,3'd0,6'd5, 2'd0,8'd255,8'd197}, // R7
    {3'd2,3'd0,3'd0,2'd0,3'd0,6'd63,2'd0,8'd0,  8'd63},  // R7 top index
    {3'd4,3'd0,3'd0,2'd0,3'd0,6'd0, 2'd0,8'd10, 8'd21},  // R9
    {3'd4,3'd0,3'd0,2'd0,3'd0,6'd0, 2'd0,8'd200,8'd0},   // R9 upper zero
    {3'd0,3'd0,3'd0,2'd0,3'd0,6'd0, 2'd0,8'd33, 8'd33},  // R10 pass
    {3'd6,3'd0,3'd0,2'd0,3'd0,6'd0, 2'd0,8'd77, 8'd77}   // R10 reserved
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic in_ready, out_valid;
  logic [W-1:0] in_row = '0, out_row;
  logic [2:0] in_op = '0, in_src_a = '0, in_src_b = '0, in_amt = '0;
  logic [1:0] in_mask_sel = '0, in_dst = '0, out_dst;
  logic [5:0] in_bidx = '0;
  int checks = 0, failures = 0;
  logic [W-1:0] pat_idx, pat_par;

  always #2.5 clk = ~clk;

  rsu_row_shuffle dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int obyte(input int i);
    return int'(out_row[i*8 +: 8]);
  endfunction

  task automatic issue(input logic [2:0] op, sa, sb, input logic [1:0] ms,
                       input logic [2:0] amt, input logic [5:0] bi, input logic [1:0] dst,
                       input logic [W-1:0] row);
    @(negedge clk);
    in_op = op; in_src_a = sa; in_src_b = sb; in_mask_sel = ms;
    in_amt = amt; in_bidx = bi; in_dst = dst; in_row = row; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #(5.0 * 100000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < RB; i++) begin
      pat_idx[i*8 +: 8] = 8'(i);
      pat_par[i*8 +: 8] = 8'(i & 1);
    end
    repeat (3) @(negedge clk);
    chk("R1 out_valid after reset", int'(out_valid), 0);
    rst_n = 1'b1;
    // R1: register 0 reads zero after reset
    issue(3'd0, 3'd1, 3'd0, 2'd0, 3'd0, 6'd0, 2'd2, pat_idx);
    chk("R1 reg0 reset value", obyte(9), 0);
    chk("R3 out_valid after accept", int'(out_valid), 1);
    chk("R3 out_dst", int'(out_dst), 2);

    for (int v = 0; v < NV; v++) begin
      issue(VEC[v][37:35], VEC[v][34:32], VEC[v][31:29], VEC[v][28:27],
            VEC[v][26:24], VEC[v][23:18], VEC[v][17:16], pat_idx);
      chk($sformatf("vector %0d (R5/R6/R7/R9/R10)", v), obyte(int'(VEC[v][15:8])),
          int'(VEC[v][7:0]));
    end

    // R4: constant sources
    issue(3'd0, 3'd6, 3'd0, 2'd0, 3'd0, 6'd0, 2'd0, pat_idx);
    chk("R4 ones source", obyte(100), 255);
    issue(3'd0, 3'd5, 3'd0, 2'd0, 3'd0, 6'd0, 2'd0, pat_idx);
    chk("R4 zero source", obyte(100), 0);

    // R8: mask in reg1 (parity bytes), A = index row, B = ones
    issue(3'd0, 3'd0, 3'd0, 2'd0, 3'd0, 6'd0, 2'd1, pat_par);
    issue(3'd3, 3'd0, 3'd6, 2'd1, 3'd0, 6'd0, 2'd3, pat_idx);
    chk("R8 merge even byte takes A", obyte(4), 4);
    chk("R8 merge odd byte takes B", obyte(5), 255);
    // R4/R3: last-result source and register read-back
    issue(3'd1, 3'd7, 3'd0, 2'd0, 3'd0, 6'd0, 2'd0, pat_idx);
    chk("R4 last-result source", obyte(4), 255);
    issue(3'd0, 3'd4, 3'd0, 2'd0, 3'd0, 6'd0, 2'd2, '0);
    chk("R3 reg3 holds merge result", obyte(6), 6);

    // R2/R11: stall with a pending write of ones into reg0 (currently rotate result)
    issue(3'd0, 3'd5, 3'd0, 2'd0, 3'd0, 6'd0, 2'd0, pat_idx); // reg0 <= zero
    @(negedge clk);
    issue(3'd0, 3'd0, 3'd0, 2'd0, 3'd0, 6'd0, 2'd1, pat_idx); // out holds index row
    out_ready = 1'b0;
    @(negedge clk);
    in_op = 3'd0; in_src_a = 3'd6; in_dst = 2'd0; in_valid = 1'b1;
    @(negedge clk);
    chk("R2 in_ready low while stalled", int'(in_ready), 0);
    @(negedge clk);
    chk("R2 out_row held", obyte(7), 7);
    chk("R2 out_valid held", int'(out_valid), 1);
    chk("R2 out_dst held", int'(out_dst), 1);
    in_valid = 1'b0; out_ready = 1'b1;
    @(negedge clk);
    chk("R2 in_ready after release", int'(in_ready), 1);
    issue(3'd0, 3'd1, 3'd0, 2'd0, 3'd0, 6'd0, 2'd2, pat_idx);
    chk("R11 reg0 untouched by stalled command", obyte(7), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule